// File: doc/BRIEF.md
# Programmable Event Counter with Qualifiers

This block is one programmable performance counter. A set of per-cycle event lines is arranged as groups of eight sub-event lanes. A 32-bit configuration word picks one group and a mask of lanes within it. The block adds up the asserted lanes in each cycle. It then compares that population against an optional threshold, can reverse the sense of the comparison, and can reduce the result to a rising-edge pulse. The outcome is accumulated into a 48-bit counter.

Software programs the configuration word through a write strobe and can read it back. It can also read the counter and preload it at any time. The counter raises no interrupt, has no link to any neighbouring counter, and wraps silently.

Top module: `evc_counter`

## Requirements
- R1: After reset the counter reads 0 and the configuration word reads 0, so counting is disabled.
- R2: The select field cfg[7:0] = g picks the lanes evt_i[g*8 +: 8], where lane k is sub-event k. Unit-mask bit cfg[8+k] admits lane k, and several mask bits combine their lanes. A select value of NUM_GROUPS or above admits no lane.
- R3: With threshold cfg[31:24] = 0, each enabled cycle adds the number of admitted lanes that are asserted (0 to 8). The invert bit has no effect in this case.
- R4: With a nonzero threshold and invert cfg[23] = 0, an enabled cycle adds 1 when the population is greater than or equal to the threshold, and adds 0 otherwise.
- R5: With a nonzero threshold and invert cfg[23] = 1, an enabled cycle adds 1 when the population is strictly below the threshold, and adds 0 otherwise.
- R6: With edge bit cfg[18] = 1, the counter adds 1 only in a cycle where the qualified condition is true and was false in the previous enabled cycle. With a zero threshold, the condition is "population at least 1". A held condition never adds twice in a row.
- R7: While enable cfg[22] = 0 the counter holds its value. The edge history is cleared during that time, so a condition that is already true when counting is re-enabled counts as a new edge.
- R8: A counter write loads cnt_wdata_i at the clock edge. The increment from that same cycle is dropped.
- R9: The counter is 48 bits wide and wraps from all-ones to zero without any indication.
- R10: The configuration word reads back the written fields at their positions. Bits 17:16, 21:19 and all other unused positions read 0. The new value governs counting from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_GROUPS*8 | Per-cycle event lanes, eight per group |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 32 | Configuration write value |
| cfg_o | output | 32 | Configuration readback |
| cnt_we_i | input | 1 | Counter preload strobe |
| cnt_wdata_i | input | CNT_W | Counter preload value |
| cnt_o | output | CNT_W | Counter value |

## Verification
The step-size assertions work on the difference between consecutive counter values. They assume that no preload occurred in the cycle being measured, and they skip any cycle with a write. The rule against counting twice in a row in edge mode also assumes the configuration word did not change between the two cycles. For that reason the assertion is gated on the configuration strobe.

The bench changes inputs only on the falling clock edge and holds the lanes steady across each sampled edge. Whenever it reconfigures, it first parks the counter with enable low and then preloads it, so each scenario starts from a known value with no step ever crossing a write.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int LANES     = 8;
  localparam int POP_W     = $clog2(LANES + 1);
  localparam int CFG_W     = 32;
  localparam int SEL_LSB   = 0;
  localparam int UMASK_LSB = 8;
  localparam int EDGE_BIT  = 18;
  localparam int EN_BIT    = 22;
  localparam int INV_BIT   = 23;
  localparam int THR_LSB   = 24;

  typedef struct packed {
    logic [7:0] thr;
    logic       inv;
    logic       en;
    logic       edge_det;
    logic [7:0] umask;
    logic [7:0] sel;
  } evc_cfg_t;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_SUM   = 2'd1,
    MODE_LEVEL = 2'd2,
    MODE_EDGE  = 2'd3
  } evc_mode_e;

  function automatic evc_cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
    evc_cfg_t c;
    c.sel      = w[SEL_LSB +: 8];
    c.umask    = w[UMASK_LSB +: 8];
    c.edge_det = w[EDGE_BIT];
    c.en       = w[EN_BIT];
    c.inv      = w[INV_BIT];
    c.thr      = w[THR_LSB +: 8];
    return c;
  endfunction

  function automatic logic [CFG_W-1:0] cfg_pack(input evc_cfg_t c);
    logic [CFG_W-1:0] w;
    w                    = '0;
    w[SEL_LSB +: 8]      = c.sel;
    w[UMASK_LSB +: 8]    = c.umask;
    w[EDGE_BIT]          = c.edge_det;
    w[EN_BIT]            = c.en;
    w[INV_BIT]           = c.inv;
    w[THR_LSB +: 8]      = c.thr;
    return w;
  endfunction
endpackage

// File: rtl/evc_cfg_reg.sv
module evc_cfg_reg
  import evc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output evc_cfg_t         cfg_o,
  output logic [CFG_W-1:0] rdata_o
);
  evc_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (we_i) cfg_q <= cfg_unpack(wdata_i);
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = cfg_pack(cfg_q);
endmodule

// File: rtl/evc_select.sv
module evc_select
  import evc_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  localparam int EVT_W     = NUM_GROUPS * LANES
) (
  input  logic [EVT_W-1:0] evt_i,
  input  logic [7:0]       sel_i,
  input  logic [7:0]       umask_i,
  output logic [POP_W-1:0] pop_o
);
  logic [NUM_GROUPS-1:0] grp_hit;
  logic [LANES-1:0]      lanes;
  logic [LANES-1:0]      admitted;

  // one comparator per group; out-of-range selects hit nothing
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_hit
    assign grp_hit[g] = (sel_i == 8'(g));
  end

  always_comb begin
    lanes = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (grp_hit[g]) lanes = lanes | evt_i[g*LANES +: LANES];
    end
  end

  assign admitted = lanes & umask_i;

  always_comb begin
    pop_o = '0;
    for (int k = 0; k < LANES; k++) pop_o = pop_o + POP_W'(admitted[k]);
  end
endmodule

// File: rtl/evc_qualify.sv
module evc_qualify
  import evc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  evc_cfg_t         cfg_i,
  input  logic [POP_W-1:0] pop_i,
  output logic [POP_W-1:0] inc_o
);
  evc_mode_e  mode;
  logic [7:0] pop_ext;
  logic       cond;
  logic       hist_q;

  assign pop_ext = 8'(pop_i);

  always_comb begin
    if (!cfg_i.en)             mode = MODE_OFF;
    else if (cfg_i.edge_det)   mode = MODE_EDGE;
    else if (cfg_i.thr == '0)  mode = MODE_SUM;
    else                       mode = MODE_LEVEL;
  end

  // invert only matters once a threshold is programmed
  always_comb begin
    if (cfg_i.thr == '0) cond = (pop_ext != '0);
    else if (cfg_i.inv)  cond = (pop_ext <  cfg_i.thr);
    else                 cond = (pop_ext >= cfg_i.thr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hist_q <= 1'b0;
    else if (!cfg_i.en) hist_q <= 1'b0;
    else                hist_q <= cond;
  end

  always_comb begin
    unique case (mode)
      MODE_SUM:   inc_o = pop_i;
      MODE_LEVEL: inc_o = POP_W'(cond);
      MODE_EDGE:  inc_o = POP_W'(cond & ~hist_q);
      default:    inc_o = '0;
    endcase
  end
endmodule

// File: rtl/evc_accum.sv
module evc_accum #(
  parameter int CNT_W = 48,
  parameter int INC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  // preload wins; the add wraps modulo 2**CNT_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (we_i) cnt_q <= wdata_i;
    else           cnt_q <= cnt_q + CNT_W'(inc_i);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/evc_counter.sv
module evc_counter
  import evc_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int CNT_W      = 48,
  localparam int EVT_W     = NUM_GROUPS * LANES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_o,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] cnt_wdata_i,
  output logic [CNT_W-1:0] cnt_o
);
  evc_cfg_t         cfg;
  logic [POP_W-1:0] pop;
  logic [POP_W-1:0] inc;

  evc_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg),
    .rdata_o (cfg_o)
  );

  evc_select #(.NUM_GROUPS(NUM_GROUPS)) u_sel (
    .evt_i   (evt_i),
    .sel_i   (cfg.sel),
    .umask_i (cfg.umask),
    .pop_o   (pop)
  );

  evc_qualify u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg),
    .pop_i  (pop),
    .inc_o  (inc)
  );

  evc_accum #(.CNT_W(CNT_W), .INC_W(POP_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cnt_we_i),
    .wdata_i (cnt_wdata_i),
    .inc_i   (inc),
    .cnt_o   (cnt_o)
  );
endmodule

// File: rtl/evc_counter_chk.sv
module evc_counter_chk
  import evc_pkg::*;
#(
  parameter int CNT_W = 48
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [CFG_W-1:0] cfg_o,
  input logic             cnt_we_i,
  input logic [CNT_W-1:0] cnt_wdata_i,
  input logic [CNT_W-1:0] cnt_o
);
  logic [1:0] seen_q;
  logic       armed;
  logic       en_now;
  logic       edge_now;
  logic       thr_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              seen_q <= '0;
    else if (seen_q != 2'd3)  seen_q <= seen_q + 2'd1;
  end

  assign armed    = (seen_q >= 2'd2);
  assign en_now   = cfg_o[EN_BIT];
  assign edge_now = cfg_o[EN_BIT] & cfg_o[EDGE_BIT];
  assign thr_now  = cfg_o[EN_BIT] & ~cfg_o[EDGE_BIT] & (cfg_o[THR_LSB +: 8] != 8'd0);

  p_sw_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    $past(cnt_we_i) |-> cnt_o == $past(cnt_wdata_i));

  p_disabled_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    ($past(!cnt_we_i) && $past(!en_now)) |-> cnt_o == $past(cnt_o));

  p_pop_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    $past(!cnt_we_i) |-> (cnt_o - $past(cnt_o)) <= CNT_W'(LANES));

  p_thr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    ($past(!cnt_we_i) && $past(thr_now)) |-> (cnt_o - $past(cnt_o)) <= CNT_W'(1));

  p_edge_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    ($past(!cnt_we_i) && $past(edge_now)) |-> (cnt_o - $past(cnt_o)) <= CNT_W'(1));

  p_edge_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !armed)
    ($past(edge_now, 2) && !$past(cnt_we_i, 2) && !$past(cfg_we_i, 2) && !$past(cnt_we_i)
     && (($past(cnt_o) - $past(cnt_o, 2)) == CNT_W'(1))) |-> cnt_o == $past(cnt_o));
endmodule

bind evc_counter evc_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_o       (cfg_o),
  .cnt_we_i    (cnt_we_i),
  .cnt_wdata_i (cnt_wdata_i),
  .cnt_o       (cnt_o)
);

// File: tb/evc_counter_tb.sv
module evc_counter_tb;
  localparam int NG    = 4;
  localparam int CW    = 48;
  localparam int EW    = NG * 8;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [EW-1:0] evt_i = '0;
  logic          cfg_we_i = 1'b0;
  logic [31:0]   cfg_wdata_i = '0;
  logic [31:0]   cfg_o;
  logic          cnt_we_i = 1'b0;
  logic [CW-1:0] cnt_wdata_i = '0;
  logic [CW-1:0] cnt_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  evc_counter #(.NUM_GROUPS(NG), .CNT_W(CW)) u_dut (
    .clk_i, .rst_ni, .evt_i, .cfg_we_i, .cfg_wdata_i, .cfg_o,
    .cnt_we_i, .cnt_wdata_i, .cnt_o
  );

  function automatic logic [31:0] mk_cfg(input logic [7:0] sel, input logic [7:0] um,
                                         input logic ed, input logic en, input logic inv,
                                         input logic [7:0] thr);
    return {thr, inv, en, 3'b000, ed, 2'b00, um, sel};
  endfunction

  task automatic drive(input logic cwe, input logic [31:0] cd, input logic nwe,
                       input logic [CW-1:0] nd, input logic [EW-1:0] ev);
    @(negedge clk_i);
    cfg_we_i = cwe; cfg_wdata_i = cd; cnt_we_i = nwe; cnt_wdata_i = nd; evt_i = ev;
  endtask

  task automatic ev(input logic [EW-1:0] e);
    drive(1'b0, '0, 1'b0, '0, e);
  endtask

  task automatic prep(input logic [31:0] c, input logic [CW-1:0] pre);
    drive(1'b1, 32'h0, 1'b0, '0, '0);
    drive(1'b0, '0, 1'b1, pre, '0);
    drive(1'b1, c, 1'b0, '0, '0);
  endtask

  task automatic check_cnt(input logic [CW-1:0] exp, input string req);
    @(posedge clk_i); #5;
    checks++;
    if (cnt_o !== exp) begin
      errors++;
      $display("FAIL %s: cnt actual %0h expected %0h", req, cnt_o, exp);
    end
  endtask

  task automatic check_cfg(input logic [31:0] exp, input string req);
    @(posedge clk_i); #5;
    checks++;
    if (cfg_o !== exp) begin
      errors++;
      $display("FAIL %s: cfg actual %h expected %h", req, cfg_o, exp);
    end
  endtask

  task automatic t_reset;
    checks += 2;
    if (cnt_o !== '0) begin errors++; $display("FAIL R1: cnt actual %0h expected 0", cnt_o); end
    if (cfg_o !== '0) begin errors++; $display("FAIL R1: cfg actual %h expected 0", cfg_o); end
  endtask

  task automatic t_cfg_r10;
    drive(1'b1, 32'hFFFF_FFFF, 1'b0, '0, '0);
    check_cfg(32'hFFC4_FFFF, "R10");
    drive(1'b1, mk_cfg(8'h02, 8'hA5, 1'b1, 1'b1, 1'b1, 8'h05), 1'b0, '0, '0);
    check_cfg(32'h05C4_A502, "R10");
  endtask

  task automatic t_sum_r3;
    prep(mk_cfg(8'd1, 8'h0F, 1'b0, 1'b1, 1'b0, 8'd0), '0);
    ev(32'h0000_FF00); ev(32'h0000_0500); ev(32'h0000_00FF); ev(32'h0000_F000);
    check_cnt(48'd6, "R3");
    prep(mk_cfg(8'd1, 8'h0F, 1'b0, 1'b1, 1'b1, 8'd0), '0);
    ev(32'h0000_FF00); ev(32'h0000_0500); ev(32'h0000_00FF); ev(32'h0000_F000);
    check_cnt(48'd6, "R3 invert ignored");
  endtask

  task automatic t_select_r2;
    prep(mk_cfg(8'd2, 8'h03, 1'b0, 1'b1, 1'b0, 8'd0), '0);
    ev(32'h0001_0000); ev(32'h0003_0000); ev(32'hFF02_0000);
    check_cnt(48'd4, "R2");
    prep(mk_cfg(8'd7, 8'hFF, 1'b0, 1'b1, 1'b0, 8'd0), '0);
    ev(32'hFFFF_FFFF); ev(32'hFFFF_FFFF); ev(32'hFFFF_FFFF);
    check_cnt(48'd0, "R2 out of range");
  endtask

  task automatic t_thr_r4;
    prep(mk_cfg(8'd0, 8'hFF, 1'b0, 1'b1, 1'b0, 8'd2), '0);
    ev(32'h01); ev(32'h03); ev(32'h07); ev(32'hFF); ev(32'h00);
    check_cnt(48'd3, "R4");
  endtask

  task automatic t_inv_r5;
    prep(mk_cfg(8'd0, 8'hFF, 1'b0, 1'b1, 1'b1, 8'd2), '0);
    ev(32'h01); ev(32'h03); ev(32'h07); ev(32'hFF); ev(32'h00);
    check_cnt(48'd2, "R5");
  endtask

  task automatic t_edge_r6;
    prep(mk_cfg(8'd0, 8'hFF, 1'b1, 1'b1, 1'b0, 8'd0), '0);
    ev(32'h01); ev(32'h01); ev(32'h01); ev(32'h00); ev(32'h03); ev(32'h00); ev(32'h10);
    check_cnt(48'd3, "R6");
    prep(mk_cfg(8'd0, 8'hFF, 1'b1, 1'b1, 1'b1, 8'd3), '0);
    ev(32'h1F); ev(32'h01); ev(32'h02); ev(32'h0F); ev(32'h00); ev(32'h03); ev(32'h7F);
    check_cnt(48'd2, "R6 inverted");
  endtask

  task automatic t_disable_r7;
    prep(mk_cfg(8'd0, 8'hFF, 1'b0, 1'b0, 1'b0, 8'd0), 48'd9);
    ev(32'hFF); ev(32'hFF); ev(32'hFF);
    check_cnt(48'd9, "R7 hold");
    prep(mk_cfg(8'd0, 8'hFF, 1'b1, 1'b1, 1'b0, 8'd0), '0);
    ev(32'h01); ev(32'h01); ev(32'h01); ev(32'h01);
    drive(1'b1, mk_cfg(8'd0, 8'hFF, 1'b1, 1'b0, 1'b0, 8'd0), 1'b0, '0, 32'h01);
    ev(32'h01); ev(32'h01);
    drive(1'b1, mk_cfg(8'd0, 8'hFF, 1'b1, 1'b1, 1'b0, 8'd0), 1'b0, '0, 32'h01);
    ev(32'h01); ev(32'h01);
    check_cnt(48'd2, "R7 history");
  endtask

  task automatic t_write_r8;
    prep(mk_cfg(8'd0, 8'hFF, 1'b0, 1'b1, 1'b0, 8'd0), '0);
    ev(32'h03); ev(32'h03);
    check_cnt(48'd4, "R8 pre");
    drive(1'b0, '0, 1'b1, 48'd100, 32'h07);
    check_cnt(48'd100, "R8 priority");
    ev(32'h01);
    check_cnt(48'd101, "R8 resume");
  endtask

  task automatic t_wrap_r9;
    prep(mk_cfg(8'd0, 8'hFF, 1'b0, 1'b1, 1'b0, 8'd0), 48'hFFFF_FFFF_FFFE);
    ev(32'h07);
    check_cnt(48'd1, "R9");
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #4_000_000;
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    #35 rst_ni = 1'b1;
    #2;
    t_reset();
    t_cfg_r10();
    t_sum_r3();
    t_select_r2();
    t_thr_r4();
    t_inv_r5();
    t_edge_r6();
    t_disable_r7();
    t_write_r8();
    t_wrap_r9();
    finish_run();
  end
endmodule